// File: doc/BRIEF.md
# Self-Timed Session-Request Data Pulse Generator

This block times the data-line pulse that a USB OTG B-device sends when it asks the A-device to start a session. Software writes a one to a start bit. The block then raises the data-line pull-up drive and holds it for a fixed number of clock cycles. When that count runs out it drops the drive, and it clears the start bit and a pulse-active status bit by itself. Software either polls those two bits until both read zero, or it waits for an interrupt that tells it the A-side has powered the bus.

The pulse length is the product of two parameters: clock cycles per millisecond and the pulse length in milliseconds, which defaults to seven. An elaboration-time check rejects any setting that falls outside the allowed window of more than five and less than ten milliseconds. The VBUS-valid input is asynchronous and passes through a synchronizer of parameterised depth. A parameter also selects the polarity of the pull-up drive.

Top module: `srp_pulse_gen`

## Requirements
- R1: When start_wr is high at a clock edge while no pulse is in progress, start_bit, pulse_active and the pull-up drive are all asserted from that edge onward.
- R2: A pulse lasts exactly PULSE_MS*CLK_PER_MS clock cycles, then ends without any further input. This count is always more than 5*CLK_PER_MS and less than 10*CLK_PER_MS cycles.
- R3: start_bit and pulse_active always hold the same value, and both read zero from the cycle after the last pulse cycle.
- R4: pullup_en equals pulse_active when PULLUP_ACT_HIGH is 1, and equals its inverse when PULLUP_ACT_HIGH is 0.
- R5: A start_wr strobe that arrives while a pulse is in progress, including in its last cycle, is ignored. The pulse length does not change and no second pulse follows.
- R6: When the synchronised VBUS-valid level is high after a pulse has ended, vbus_irq goes high for exactly one cycle. With SYNC_STAGES=2 and vbus_valid rising after the pulse, vbus_irq is seen high in the third cycle after the rise. If vbus_valid is already high when the pulse ends, vbus_irq is high in the second cycle after the pulse ends. Each pulse gives at most one interrupt.
- R7: vbus_irq stays low while a pulse is in progress, and it stays low when no pulse has ended since reset.
- R8: An active-low asynchronous reset ends any pulse at once, drives start_bit, pulse_active and vbus_irq low and the pull-up drive inactive, and discards any pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_wr | input | 1 | Strobe: software writes one to the start bit |
| vbus_valid | input | 1 | Asynchronous VBUS-valid level from the bus monitor |
| start_bit | output | 1 | Start bit readback; clears itself when the pulse ends |
| pulse_active | output | 1 | Status bit, high while the pulse is driven |
| pullup_en | output | 1 | Data-line pull-up drive, polarity set by PULLUP_ACT_HIGH |
| vbus_irq | output | 1 | One-cycle VBUS-valid interrupt after a pulse |

## Verification
The assertions check the following on every cycle:
- the pulse begins on an accepted strobe;
- each pulse has the exact cycle count, measured by a run counter in the checker, and stays inside the five-to-ten-millisecond window;
- the start bit and the status bit stay equal;
- the interrupt lasts one cycle and never overlaps a pulse.

Only the bench scenarios can show the following:
- a repeated write at each possible offset inside a pulse has no effect on its length;
- the interrupt latency after the VBUS level rises;
- a VBUS level that is already high gives no interrupt when no pulse has taken place;
- a reset in the middle of a pulse also discards the interrupt that would otherwise follow.

// File: rtl/srp_pkg.sv
package srp_pkg;

   typedef enum logic {
      SRP_IDLE  = 1'b0,
      SRP_PULSE = 1'b1
   } srp_state_t;

   function automatic int unsigned srp_cycles(input int unsigned cyc_per_ms,
                                              input int unsigned ms);
      return cyc_per_ms * ms;
   endfunction

   function automatic int unsigned srp_cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/srp_vbus_sync.sv
module srp_vbus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srp_pulse_timer.sv
module srp_pulse_timer #(
   parameter int unsigned CYCLES = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic active,
   output logic last
);
   import srp_pkg::*;

   localparam int unsigned CW = srp_cnt_width(CYCLES);
   localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

   srp_state_t     state;
   logic [CW-1:0]  cnt;

   assign active = (state == SRP_PULSE);
   assign last   = active && (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SRP_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SRP_IDLE: begin
               cnt <= '0;
               if (launch) state <= SRP_PULSE;
            end
            SRP_PULSE: begin
               if (cnt == LAST_CNT) begin
                  state <= SRP_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SRP_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/srp_irq_arm.sv
module srp_irq_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_end,
   input  logic launch,
   input  logic vbus_s,
   output logic irq
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (launch) begin
            armed <= 1'b0;
         end else if (pulse_end) begin
            armed <= 1'b1;
         end else if (armed && vbus_s) begin
            armed <= 1'b0;
            irq   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/srp_pulse_gen.sv
module srp_pulse_gen #(
   parameter int unsigned CLK_PER_MS      = 60000,
   parameter int unsigned PULSE_MS        = 7,
   parameter int unsigned MIN_MS          = 5,
   parameter int unsigned MAX_MS          = 10,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter bit          PULLUP_ACT_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_wr,
   input  logic vbus_valid,
   output logic start_bit,
   output logic pulse_active,
   output logic pullup_en,
   output logic vbus_irq
);
   import srp_pkg::*;

   localparam int unsigned PULSE_CYC = srp_cycles(CLK_PER_MS, PULSE_MS);
   localparam int unsigned MIN_CYC   = srp_cycles(CLK_PER_MS, MIN_MS);
   localparam int unsigned MAX_CYC   = srp_cycles(CLK_PER_MS, MAX_MS);

   generate
      if (CLK_PER_MS < 1) begin : g_bad_clk
         $error("srp_pulse_gen: CLK_PER_MS must be at least 1");
      end
      if (PULSE_CYC <= MIN_CYC || PULSE_CYC >= MAX_CYC) begin : g_bad_len
         $error("srp_pulse_gen: pulse length outside the allowed window");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("srp_pulse_gen: SYNC_STAGES above 4 not supported");
      end
   endgenerate

   logic active_q;
   logic last_cyc;
   logic launch;
   logic vbus_s;
   logic start_q;

   assign launch = start_wr && !active_q;

   srp_pulse_timer #(.CYCLES(PULSE_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .active (active_q),
      .last   (last_cyc)
   );

   srp_vbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (vbus_valid),
      .q     (vbus_s)
   );

   srp_irq_arm u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_end (last_cyc),
      .launch    (launch),
      .vbus_s    (vbus_s),
      .irq       (vbus_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_q <= 1'b0;
      else if (launch)   start_q <= 1'b1;
      else if (last_cyc) start_q <= 1'b0;
   end

   assign start_bit    = start_q;
   assign pulse_active = active_q;

   generate
      if (PULLUP_ACT_HIGH) begin : g_pu_high
         assign pullup_en = active_q;
      end else begin : g_pu_low
         assign pullup_en = !active_q;
      end
   endgenerate

endmodule

// File: rtl/srp_pulse_gen_chk.sv
module srp_pulse_gen_chk #(
   parameter int unsigned CLK_PER_MS      = 60000,
   parameter int unsigned PULSE_MS        = 7,
   parameter int unsigned MIN_MS          = 5,
   parameter int unsigned MAX_MS          = 10,
   parameter bit          PULLUP_ACT_HIGH = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic start_wr,
   input logic start_bit,
   input logic pulse_active,
   input logic pullup_en,
   input logic vbus_irq
);

   localparam int unsigned PULSE_CYC = CLK_PER_MS * PULSE_MS;
   localparam int unsigned MIN_CYC   = CLK_PER_MS * MIN_MS;
   localparam int unsigned MAX_CYC   = CLK_PER_MS * MAX_MS;

   int unsigned run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run <= 0;
      else if (pulse_active) run <= run + 1;
      else                   run <= 0;
   end

   a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_active && start_wr) |=> (pulse_active && start_bit));

   a_r2_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_active) |-> (run == PULSE_CYC));

   a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_active) |-> (run > MIN_CYC && run < MAX_CYC));

   a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_active |-> (run < MAX_CYC));

   a_r3_bits_match: assert property (@(posedge clk) disable iff (!rst_n)
      start_bit == pulse_active);

   a_r4_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_en == (PULLUP_ACT_HIGH ? pulse_active : !pulse_active));

   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_irq |=> !vbus_irq);

   a_r7_quiet_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_irq |-> !pulse_active);

   a_r8_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (!start_bit && !pulse_active && !vbus_irq));

endmodule

bind srp_pulse_gen srp_pulse_gen_chk #(
   .CLK_PER_MS      (CLK_PER_MS),
   .PULSE_MS        (PULSE_MS),
   .MIN_MS          (MIN_MS),
   .MAX_MS          (MAX_MS),
   .PULLUP_ACT_HIGH (PULLUP_ACT_HIGH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_wr     (start_wr),
   .start_bit    (start_bit),
   .pulse_active (pulse_active),
   .pullup_en    (pullup_en),
   .vbus_irq     (vbus_irq)
);

// File: tb/sim_srp_pulse_gen.sv
`timescale 1ns/1ps
module sim_srp_pulse_gen;

   localparam int CPM = 4;
   localparam int PMS = 7;
   localparam int P   = CPM * PMS;

   logic clk = 1'b0;
   logic rst_n;
   logic start_wr;
   logic vbus_valid;
   logic start_bit, pulse_active, pullup_en, vbus_irq;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #2.5 clk = ~clk;

   srp_pulse_gen #(
      .CLK_PER_MS(CPM), .PULSE_MS(PMS), .SYNC_STAGES(2), .PULLUP_ACT_HIGH(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .vbus_valid(vbus_valid),
      .start_bit(start_bit), .pulse_active(pulse_active),
      .pullup_en(pullup_en), .vbus_irq(vbus_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         finish_run();
      end
   end

   // strobe start; return at the sample after the capturing edge
   task automatic strobe();
      @(negedge clk) start_wr = 1'b1;
      @(negedge clk) start_wr = 1'b0;
   endtask

   // count active samples; rewrite start when len == rw_at; track irq
   task automatic measure(input int rw_at, output int len, output int irq_seen);
      len = 0;
      irq_seen = 0;
      while (pulse_active && len < 100) begin
         len++;
         if (!start_bit || !pullup_en) irq_seen += 100;
         if (vbus_irq) irq_seen++;
         start_wr = (len == rw_at);
         @(negedge clk);
      end
      start_wr = 1'b0;
   endtask

   initial begin
      int len, irqs, wait_n;
      rst_n = 1'b0;
      start_wr = 1'b0;
      vbus_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 reset start_bit", start_bit, 0);
      check("R8 reset pulse_active", pulse_active, 0);
      check("R8 reset pullup", pullup_en, 0);
      check("R8 reset irq", vbus_irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2/R3/R5: sweep of rewrite offsets, 0 means no rewrite
      for (int k = 0; k <= P; k++) begin
         strobe();
         check("R1 start sets active", pulse_active, 1);
         check("R1 start sets start_bit", start_bit, 1);
         measure(k, len, irqs);
         check("R2 R5 pulse length", len, P);
         check("R3 R4 bits high during pulse", irqs, 0);
         check("R3 start_bit cleared", start_bit, 0);
         check("R4 pullup released", pullup_en, 0);
         @(negedge clk);
         check("R5 no second pulse", pulse_active, 0);
         check("R7 no irq without vbus", vbus_irq, 0);
      end

      // R6: vbus already high when pulse ends
      strobe();
      vbus_valid = 1'b1;
      measure(0, len, irqs);
      check("R7 no irq during pulse", irqs, 0);
      check("R6 irq not in first idle cycle", vbus_irq, 0);
      @(negedge clk);
      check("R6 irq in second idle cycle", vbus_irq, 1);
      @(negedge clk);
      check("R6 irq one cycle", vbus_irq, 0);
      irqs = 0;
      repeat (10) begin
         @(negedge clk);
         irqs += vbus_irq;
      end
      check("R6 single irq per pulse", irqs, 0);

      // R6: vbus rises after the pulse has ended
      vbus_valid = 1'b0;
      repeat (4) @(negedge clk);
      strobe();
      measure(0, len, irqs);
      repeat (5) @(negedge clk);
      check("R6 no irq while vbus low", vbus_irq, 0);
      vbus_valid = 1'b1;
      wait_n = 0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (vbus_irq && wait_n == 0) wait_n = i;
      end
      check("R6 irq latency after vbus rise", wait_n, 3);

      // R7: vbus high with no pulse since reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      irqs = 0;
      repeat (10) begin
         @(negedge clk);
         irqs += vbus_irq;
      end
      check("R7 no irq without pulse", irqs, 0);

      // R8: reset mid-pulse ends the pulse and discards the armed irq
      strobe();
      repeat (10) @(negedge clk);
      check("R8 pulse running before reset", pulse_active, 1);
      #1 rst_n = 1'b0;
      #0.5;
      check("R8 async clear active", pulse_active, 0);
      check("R8 async clear start_bit", start_bit, 0);
      check("R8 async clear pullup", pullup_en, 0);
      @(negedge clk);
      rst_n = 1'b1;
      irqs = 0;
      len = 0;
      repeat (P + 10) begin
         @(negedge clk);
         irqs += vbus_irq;
         len += pulse_active;
      end
      check("R8 no resumed pulse", len, 0);
      check("R8 no irq after reset", irqs, 0);

      finish_run();
   end

endmodule